// File: doc/BRIEF.md
# Eight-Bit General-Purpose I/O Port with Transmit Pin Takeover

The block is an eight-pin general-purpose I/O port that sits on a simple synchronous register bus. Two registers are mapped on the bus. The output latch holds the value that each pin drives. The direction register switches each pin's output buffer on or off, one bit per pin. Pin levels coming in from the pads pass through a two-flop synchronizer before any read can see them.

A serial transmitter can claim pin 0 as its transmit output. While its enable input is high, pin 0 drives the transmit bit with its buffer forced on, whatever the direction bit says. A port read is handled differently: on every pin, including the claimed one, the direction bit alone decides whether the read returns the latch or the synchronized pin level. Software can load the latch while a pin is still an input. When that pin is later turned to output, it drives the prepared value from its first cycle.

Top module: `gpio_port_ovr`

## Requirements
- R1: After a synchronous reset, the output latch and the direction register are both 0x00, and every output enable is low.
- R2: A bus write to offset 0x0C stores all eight bits of write data into the direction register on that clock edge. A read at offset 0x0C returns the stored value.
- R3: A bus write to offset 0x08 stores the write data into the output latch on that clock edge, whatever the direction bits are.
- R4: When the transmit enable is low, each pin's output enable equals its direction bit, where 1 turns the buffer on.
- R5: When the transmit enable is high, pin 0 has its output enable at 1 and drives the transmit data input, regardless of direction bit 0.
- R6: When the transmit enable is low, pin 0 drives latch bit 0 like every other pin, and every pin's output equals its latch bit.
- R7: A read at offset 0x08 returns, for each bit, the latch bit when the direction bit is 1 and the synchronized pin level when it is 0. Pin 0 follows the same rule while the transmitter owns it.
- R8: A change on a pin input first shows in a read after exactly two rising clock edges; after one edge the read still shows the old level.
- R9: A read at any offset other than 0x08 and 0x0C returns 0x00. A write to such an offset changes neither the latch nor the direction register.
- R10: If the latch is loaded before a direction bit goes from 0 to 1, the pin drives the loaded value in the same cycle its output enable rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 8 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the offset |
| pin_in | input | 8 | Pad input levels, asynchronous |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output buffer enables |
| ser_en | input | 1 | Transmitter owns pin 0 while high |
| ser_txd | input | 1 | Transmit data for pin 0 |

## Verification
A corrupted latch or direction bit shows on the pads at the next clock edge. It appears as a wrong pin_out or pin_oe value, unless the transmitter is hiding that bit on pin 0. The same fault shows in the read of either register in the cycle the offset is presented. A fault in the synchronizer path only shows on pins whose direction bit is 0. It appears two edges after the pin changes, as a read that comes a cycle early, a cycle late or never. An override fault shows only while the transmit enable is high, so the stimulus toggles that enable while both direction values are set on pin 0.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
    localparam int unsigned PORT_W   = 8;
    localparam int unsigned ADDR_W   = 8;
    localparam int unsigned OFS_DATA = 8'h08;
    localparam int unsigned OFS_DIR  = 8'h0C;
    localparam int unsigned TX_BIT   = 0;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_DATA = 2'd1,
        SEL_DIR  = 2'd2
    } reg_sel_e;

    typedef struct packed {
        logic [PORT_W-1:0] latch;
        logic [PORT_W-1:0] dir;
    } port_state_t;

    function automatic logic pick_bit(input logic use_latch, input logic lat, input logic pin);
        return use_latch ? lat : pin;
    endfunction
endpackage

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;
    logic [1:0]   since_rst;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1    <= '0;
            stage2    <= '0;
            since_rst <= '0;
        end else begin
            stage1 <= din;
            stage2 <= stage1;
            if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
        end
    end

    assign q = stage2;

    // R8: the value seen now is the input from exactly two edges ago
    a_r8_two_stage: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd2) |-> (q == $past(din, 2)));
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int unsigned W        = PORT_W,
    parameter int unsigned AW       = ADDR_W,
    parameter int unsigned DATA_OFS = OFS_DATA,
    parameter int unsigned DIR_OFS  = OFS_DIR
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [W-1:0]  bus_wdata,
    input  logic [W-1:0]  pin_level,
    output logic [W-1:0]  bus_rdata,
    output logic [W-1:0]  latch_q,
    output logic [W-1:0]  dir_q
);
    localparam logic [AW-1:0] A_DATA = AW'(DATA_OFS);
    localparam logic [AW-1:0] A_DIR  = AW'(DIR_OFS);

    reg_sel_e    sel;
    port_state_t st;
    logic [W-1:0] port_view;

    always_comb begin
        if (bus_addr == A_DATA)     sel = SEL_DATA;
        else if (bus_addr == A_DIR) sel = SEL_DIR;
        else                        sel = SEL_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (bus_wr) begin
            case (sel)
                SEL_DATA: st.latch <= bus_wdata;
                SEL_DIR:  st.dir   <= bus_wdata;
                default:  ;
            endcase
        end
    end

    assign latch_q = st.latch;
    assign dir_q   = st.dir;

    for (genvar i = 0; i < W; i++) begin : g_view
        assign port_view[i] = pick_bit(st.dir[i], st.latch[i], pin_level[i]);
    end

    always_comb begin
        case (sel)
            SEL_DATA: bus_rdata = port_view;
            SEL_DIR:  bus_rdata = st.dir;
            default:  bus_rdata = '0;
        endcase
    end

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (latch_q == '0 && dir_q == '0));
    a_r2_dir_write: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == A_DIR) |=> (dir_q == $past(bus_wdata)));
    a_r3_latch_write: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == A_DATA) |=> (latch_q == $past(bus_wdata)));
    a_r9_unmapped_write: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr != A_DATA && bus_addr != A_DIR) |=> ($stable(latch_q) && $stable(dir_q)));
    a_r9_unmapped_read: assert property (@(posedge clk) disable iff (rst)
        (bus_addr != A_DATA && bus_addr != A_DIR) |-> (bus_rdata == '0));
endmodule

// File: rtl/gpio_port_pads.sv
module gpio_port_pads #(
    parameter int unsigned W     = 8,
    parameter int unsigned SHARE = 0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] latch_q,
    input  logic [W-1:0] dir_q,
    input  logic         ser_en,
    input  logic         ser_txd,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        if (i == SHARE) begin : g_shared
            assign pin_out[i] = ser_en ? ser_txd : latch_q[i];
            assign pin_oe[i]  = ser_en | dir_q[i];
        end else begin : g_plain
            assign pin_out[i] = latch_q[i];
            assign pin_oe[i]  = dir_q[i];
        end
    end

    a_r5_tx_takeover: assert property (@(posedge clk) disable iff (rst)
        ser_en |-> (pin_oe[SHARE] && pin_out[SHARE] == ser_txd));
    a_r4_oe_from_dir: assert property (@(posedge clk) disable iff (rst)
        !ser_en |-> (pin_oe == dir_q));
    a_r6_gpio_out: assert property (@(posedge clk) disable iff (rst)
        !ser_en |-> (pin_out == latch_q));
endmodule

// File: rtl/gpio_port_ovr.sv
module gpio_port_ovr
    import gpio_port_pkg::*;
#(
    parameter int unsigned W        = PORT_W,
    parameter int unsigned AW       = ADDR_W,
    parameter int unsigned DATA_OFS = OFS_DATA,
    parameter int unsigned DIR_OFS  = OFS_DIR,
    parameter int unsigned SHARE    = TX_BIT
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [W-1:0]  bus_wdata,
    output logic [W-1:0]  bus_rdata,
    input  logic [W-1:0]  pin_in,
    output logic [W-1:0]  pin_out,
    output logic [W-1:0]  pin_oe,
    input  logic          ser_en,
    input  logic          ser_txd
);
    logic [W-1:0] pin_level;
    logic [W-1:0] latch_q;
    logic [W-1:0] dir_q;

    gpio_port_sync #(.W(W)) u_sync (
        .clk(clk), .rst(rst), .din(pin_in), .q(pin_level)
    );

    gpio_port_regs #(.W(W), .AW(AW), .DATA_OFS(DATA_OFS), .DIR_OFS(DIR_OFS)) u_regs (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .pin_level(pin_level), .bus_rdata(bus_rdata),
        .latch_q(latch_q), .dir_q(dir_q)
    );

    gpio_port_pads #(.W(W), .SHARE(SHARE)) u_pads (
        .clk(clk), .rst(rst), .latch_q(latch_q), .dir_q(dir_q),
        .ser_en(ser_en), .ser_txd(ser_txd), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    // R10: a pin turning into an output already carries its latch value
    a_r10_no_glitch: assert property (@(posedge clk) disable iff (rst)
        ($rose(pin_oe[1])) |-> (pin_out[1] == latch_q[1]));
endmodule

// File: tb/sim_gpio_port_ovr.sv
`timescale 1ns/1ps
module sim_gpio_port_ovr;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] pin_in = 8'h00;
    logic [7:0] pin_out;
    logic [7:0] pin_oe;
    logic       ser_en = 1'b0;
    logic       ser_txd = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;

    logic [7:0] m_latch = 8'h00;
    logic [7:0] m_dir = 8'h00;
    logic [7:0] m_pin = 8'h00;

    always #2 clk = ~clk;

    gpio_port_ovr u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .ser_en(ser_en), .ser_txd(ser_txd)
    );

    function automatic logic [7:0] f_out(input logic [7:0] lat, input logic en, input logic txd);
        logic [7:0] r = lat;
        if (en) r[0] = txd;
        return r;
    endfunction

    function automatic logic [7:0] f_oe(input logic [7:0] dir, input logic en);
        return dir | {7'b0, en};
    endfunction

    function automatic logic [7:0] f_port(input logic [7:0] lat, input logic [7:0] dir, input logic [7:0] pin);
        return (lat & dir) | (pin & ~dir);
    endfunction

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        if (a == 8'h08) m_latch = d;
        else if (a == 8'h0C) m_dir = d;
    endtask

    task automatic set_pins(input logic [7:0] v);
        @(negedge clk);
        pin_in = v;
        @(negedge clk);
        @(negedge clk);
        m_pin = v;
    endtask

    task automatic read_chk(input string tag, input logic [7:0] a, input logic [7:0] exp);
        bus_addr = a;
        #0.5;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic check_all(input string tag);
        #0.5;
        chk({tag, " R6/R5 pin_out"}, pin_out, f_out(m_latch, ser_en, ser_txd));
        chk({tag, " R4/R5 pin_oe"}, pin_oe, f_oe(m_dir, ser_en));
        read_chk({tag, " R7 port read"}, 8'h08, f_port(m_latch, m_dir, m_pin));
        read_chk({tag, " R2 dir read"}, 8'h0C, m_dir);
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        #0.5;
        chk("R1 oe after reset", pin_oe, 8'h00);
        chk("R1 out after reset", pin_out, 8'h00);
        read_chk("R1 dir after reset", 8'h0C, 8'h00);

        // R2 all eight direction bits writable
        bus_write(8'h0C, 8'hA5);
        check_all("R2 dir A5");
        bus_write(8'h0C, 8'h5A);
        check_all("R2 dir 5A");

        // R3 latch write while pins are inputs and outputs
        bus_write(8'h0C, 8'h00);
        bus_write(8'h08, 8'h3C);
        check_all("R3 latch as inputs");
        bus_write(8'h0C, 8'hFF);
        check_all("R3 latch visible as outputs");

        // R10 preload latch, then enable direction bit 1
        bus_write(8'h0C, 8'h00);
        bus_write(8'h08, 8'h02);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 8'h0C; bus_wdata = 8'h02;
        @(posedge clk);
        #0.5;
        chk("R10 oe rises", pin_oe, 8'h02);
        chk("R10 driven value at rise", pin_out, 8'h02);
        @(negedge clk);
        bus_wr = 1'b0;
        m_dir = 8'h02; m_latch = 8'h02;

        // R8 two-edge latency on an input pin
        bus_write(8'h0C, 8'h00);
        set_pins(8'h00);
        @(negedge clk);
        pin_in = 8'hC3;
        bus_addr = 8'h08;
        @(negedge clk);
        #0.5;
        chk("R8 after one edge", bus_rdata, f_port(m_latch, m_dir, 8'h00));
        @(negedge clk);
        #0.5;
        chk("R8 after two edges", bus_rdata, f_port(m_latch, m_dir, 8'hC3));
        m_pin = 8'hC3;

        // R5/R7 takeover of pin 0, read still follows direction bit 0
        bus_write(8'h08, 8'h00);
        set_pins(8'h01);
        @(negedge clk);
        ser_en = 1'b1; ser_txd = 1'b1;
        check_all("R5 tx dir0=0");
        read_chk("R7 shared pin read as input", 8'h08, 8'h01);
        bus_write(8'h0C, 8'h01);
        @(negedge clk); ser_txd = 1'b1;
        check_all("R5 tx dir0=1");
        read_chk("R7 shared pin read latch", 8'h08, 8'h00);
        @(negedge clk); ser_en = 1'b0;
        check_all("R6 pin0 back to gpio");

        // R9 unmapped offsets
        bus_write(8'h08, 8'h96);
        bus_write(8'h0C, 8'h69);
        bus_write(8'h04, 8'hFF);
        bus_write(8'h0D, 8'h00);
        check_all("R9 unmapped write");
        read_chk("R9 unmapped read 04", 8'h04, 8'h00);
        read_chk("R9 unmapped read FF", 8'hFF, 8'h00);

        // random mix
        for (int it = 0; it < 300; it++) begin
            int op = $urandom_range(0, 4);
            case (op)
                0: bus_write(8'h08, 8'($urandom));
                1: bus_write(8'h0C, 8'($urandom));
                2: begin
                    logic [7:0] a = 8'($urandom);
                    if (a == 8'h08 || a == 8'h0C) a = 8'h10;
                    bus_write(a, 8'($urandom));
                    read_chk("R9 random unmapped read", a, 8'h00);
                end
                3: set_pins(8'($urandom));
                default: begin
                    @(negedge clk);
                    ser_en = 1'($urandom);
                    ser_txd = 1'($urandom);
                end
            endcase
            check_all("R3/R7 random");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule